// File: doc/BRIEF.md
# Page Coherence Directory State Unit

This block holds the directory entries for a small set of shared pages in a machine whose caches are kept coherent by software. Each entry records the page's sharing state, a safe/unsafe history bit, which processors map the page for reading, which have committed writes, which have write faults whose effect is still deferred, and two small history counters. Events arrive one at a time on a valid/ready handshake that stands in for the entry lock. Each event is a read fault, a write fault, a release or an acquire check, and it carries the requesting processor and the page index.

One cycle after it accepts an event, the block returns the page's new combined state and its holder count. It also reports the set of processors that must receive write notices, and whether the requester must invalidate its local mapping. A safe page that keeps turning weak stops producing notices and becomes unsafe. From then on, acquirers poll it. An unsafe page that acquirers keep finding non-weak becomes safe again.

Top module: `pcd_dir_unit`

## Requirements
- R1: After reset every page is uncached and safe with no holders, no response is pending, and `ev_ready` is high.
- R2: An event is accepted in a cycle where `ev_valid` and `ev_ready` are both high. In the next cycle `rsp_valid` is high and the response fields describe the page after that event. In any cycle that follows no accepted event, `rsp_valid` is low. `rsp_state` is {unsafe, base}, where base is 0 uncached, 1 shared, 2 dirty and 3 weak. `ev_kind` is 0 read, 1 write, 2 release, 3 acquire.
- R3: A read fault adds the requester as a holder. On a non-weak page, a single holder gives dirty, and several holders with no committed writer give shared.
- R4: A write fault records a deferred write for the requester, who becomes a holder but not a committed writer. One holder gives dirty. Several holders with no committed writer give shared.
- R5: A release by a processor with a deferred write turns it into a committed writer. With more than one holder, a non-weak page then becomes weak.
- R6: A read, write or release that leaves two or more holders, at least one of them a committed writer, makes a non-weak page weak. Once a page is weak, reads, writes and releases leave it weak.
- R7: When a safe page turns weak and its notice count is at most NOTICE_LIMIT, `rsp_notify` lists every holder except the requester, and the notice count increments.
- R8: When a safe page turns weak and its notice count is above NOTICE_LIMIT, the page becomes unsafe and `rsp_notify` is zero.
- R9: An unsafe page that turns weak produces no notices. Only the entry changes.
- R10: An acquire on a weak page by a holder raises `rsp_inval` and removes all of that processor's mappings. Any other event gives `rsp_inval` low.
- R11: An acquire on an unsafe page that is not weak increments its check count. When the count would exceed CHECK_LIMIT, the page returns to safe with both counters cleared.
- R12: An acquire that leaves no holders makes the page uncached. A page is reported uncached exactly when its holder count is zero.
- R13: An event changes only the entry of the page it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Entry free to take an event |
| ev_kind | input | 2 | 0 read, 1 write, 2 release, 3 acquire |
| ev_proc | input | PW | Requesting processor |
| ev_page | input | AW | Page index |
| rsp_valid | output | 1 | Response for the event accepted last cycle |
| rsp_state | output | 3 | {unsafe, base} after the event |
| rsp_count | output | CNTW | Number of holders after the event |
| rsp_notify | output | NPROC | Processors to receive write notices |
| rsp_inval | output | 1 | Requester must drop its mapping |

## Verification
The bench builds the block with three processors, two pages and both limits set to one. With these values, two notice postings exhaust the notice budget, the third weak transition makes the page unsafe, and two clean acquire checks return it to safe. Every limit crossing can therefore be reached within a few events. Directed sequences walk one page through all eight combined states. A long pseudo-random sweep over every kind, processor and page then compares each response against a reference model the bench computes.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    typedef enum logic [1:0] {
        PG_UNC  = 2'd0,
        PG_SHR  = 2'd1,
        PG_DRT  = 2'd2,
        PG_WEAK = 2'd3
    } base_t;

    typedef enum logic [1:0] {
        EV_READ    = 2'd0,
        EV_WRITE   = 2'd1,
        EV_RELEASE = 2'd2,
        EV_ACQUIRE = 2'd3
    } ev_kind_t;

endpackage

// File: rtl/pcd_popcnt.sv
module pcd_popcnt #(
    parameter int W    = 4,
    parameter int OW   = 3
) (
    input  logic [W-1:0]  vec,
    output logic [OW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + OW'(vec[i]);
        end
    end
endmodule

// File: rtl/pcd_satinc.sv
module pcd_satinc #(
    parameter int W    = 2,
    parameter int MAXV = 3
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] inc
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    assign inc = (val >= TOP) ? TOP : val + W'(1);
endmodule

// File: rtl/pcd_next.sv
module pcd_next
    import pcd_pkg::*;
#(
    parameter int NPROC        = 4,
    parameter int PW           = 2,
    parameter int CW           = 2,
    parameter int CNTW         = 3,
    parameter int NOTICE_LIMIT = 2,
    parameter int CHECK_LIMIT  = 2
) (
    input  ev_kind_t            kind,
    input  logic [PW-1:0]       proc,
    input  base_t               cur_base,
    input  logic                cur_unsafe,
    input  logic [NPROC-1:0]    cur_rd,
    input  logic [NPROC-1:0]    cur_wr,
    input  logic [NPROC-1:0]    cur_pend,
    input  logic [CW-1:0]       cur_ntc,
    input  logic [CW-1:0]       cur_chk,
    output base_t               nx_base,
    output logic                nx_unsafe,
    output logic [NPROC-1:0]    nx_rd,
    output logic [NPROC-1:0]    nx_wr,
    output logic [NPROC-1:0]    nx_pend,
    output logic [CW-1:0]       nx_ntc,
    output logic [CW-1:0]       nx_chk,
    output logic [NPROC-1:0]    notify,
    output logic                inval,
    output logic [CNTW-1:0]     cnt
);
    localparam logic [CW-1:0] NLIM_C = CW'(NOTICE_LIMIT);
    localparam logic [CW-1:0] CLIM_C = CW'(CHECK_LIMIT);

    logic [NPROC-1:0] pm;
    logic [NPROC-1:0] holders_now;
    logic [NPROC-1:0] holders_nx;
    logic [CW-1:0]    ntc_inc;
    logic [CW-1:0]    chk_inc;

    always_comb begin
        for (int i = 0; i < NPROC; i++) begin
            pm[i] = (proc == PW'(i));
        end
    end

    assign holders_now = cur_rd | cur_wr | cur_pend;

    pcd_satinc #(.W(CW), .MAXV(NOTICE_LIMIT + 1)) u_ntc_inc (.val(cur_ntc), .inc(ntc_inc));
    pcd_satinc #(.W(CW), .MAXV(CHECK_LIMIT + 1))  u_chk_inc (.val(cur_chk), .inc(chk_inc));

    // mapping bitmaps
    always_comb begin
        nx_rd   = cur_rd;
        nx_wr   = cur_wr;
        nx_pend = cur_pend;
        inval   = 1'b0;
        unique case (kind)
            EV_READ: begin
                nx_rd = cur_rd | pm;
            end
            EV_WRITE: begin
                if ((cur_wr & pm) == '0) begin
                    nx_pend = cur_pend | pm;
                end
            end
            EV_RELEASE: begin
                if ((cur_pend & pm) != '0) begin
                    nx_wr   = cur_wr | pm;
                    nx_pend = cur_pend & ~pm;
                end
            end
            EV_ACQUIRE: begin
                if (cur_base == PG_WEAK && (holders_now & pm) != '0) begin
                    nx_rd   = cur_rd & ~pm;
                    nx_wr   = cur_wr & ~pm;
                    nx_pend = cur_pend & ~pm;
                    inval   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign holders_nx = nx_rd | nx_wr | nx_pend;

    pcd_popcnt #(.W(NPROC), .OW(CNTW)) u_cnt (.vec(holders_nx), .ones(cnt));

    // sharing state and history
    always_comb begin
        nx_base   = cur_base;
        nx_unsafe = cur_unsafe;
        nx_ntc    = cur_ntc;
        nx_chk    = cur_chk;
        notify    = '0;
        if (kind == EV_ACQUIRE) begin
            if (cnt == '0) begin
                nx_base = PG_UNC;
            end
            if (cur_base != PG_WEAK && cur_unsafe) begin
                if (chk_inc > CLIM_C) begin
                    nx_unsafe = 1'b0;
                    nx_chk    = '0;
                    nx_ntc    = '0;
                end else begin
                    nx_chk    = chk_inc;
                end
            end
        end else begin
            if (cur_base == PG_WEAK) begin
                nx_base = PG_WEAK;
            end else if (cnt == '0) begin
                nx_base = PG_UNC;
            end else if (cnt == CNTW'(1)) begin
                nx_base = PG_DRT;
            end else if (nx_wr != '0) begin
                nx_base = PG_WEAK;
            end else begin
                nx_base = PG_SHR;
            end
            if (cur_base != PG_WEAK && nx_base == PG_WEAK && !cur_unsafe) begin
                if (cur_ntc <= NLIM_C) begin
                    notify = holders_nx & ~pm;
                    nx_ntc = ntc_inc;
                end else begin
                    nx_unsafe = 1'b1;
                    nx_chk    = '0;
                end
            end
        end
    end
endmodule

// File: rtl/pcd_dir_unit.sv
module pcd_dir_unit
    import pcd_pkg::*;
#(
    parameter int NPROC        = 4,
    parameter int NPAGE        = 4,
    parameter int NOTICE_LIMIT = 2,
    parameter int CHECK_LIMIT  = 2,
    localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int AW   = (NPAGE > 1) ? $clog2(NPAGE) : 1,
    localparam int CNTW = $clog2(NPROC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [1:0]        ev_kind,
    input  logic [PW-1:0]     ev_proc,
    input  logic [AW-1:0]     ev_page,
    output logic              rsp_valid,
    output logic [2:0]        rsp_state,
    output logic [CNTW-1:0]   rsp_count,
    output logic [NPROC-1:0]  rsp_notify,
    output logic              rsp_inval
);
    localparam int MAXLIM = (NOTICE_LIMIT > CHECK_LIMIT) ? NOTICE_LIMIT : CHECK_LIMIT;
    localparam int CW     = $clog2(MAXLIM + 2);

    typedef struct packed {
        base_t            base;
        logic             unsafe;
        logic [NPROC-1:0] rd;
        logic [NPROC-1:0] wr;
        logic [NPROC-1:0] pend;
        logic [CW-1:0]    ntc;
        logic [CW-1:0]    chk;
    } entry_t;

    typedef struct packed {
        entry_t [NPAGE-1:0] ent;
        logic               vld;
        logic [2:0]         st;
        logic [CNTW-1:0]    cnt;
        logic [NPROC-1:0]   ntf;
        logic               inv;
    } regs_t;

    regs_t            r_d, r_q;
    entry_t           cur, nxt;
    logic             fire;
    logic [NPAGE-1:0] hit;
    logic [NPROC-1:0] nx_notify;
    logic             nx_inval;
    logic [CNTW-1:0]  nx_cnt;

    assign ev_ready = !rst;
    assign fire     = ev_valid && ev_ready;

    generate
        for (genvar g = 0; g < NPAGE; g++) begin : g_hit
            assign hit[g] = fire && (ev_page == AW'(g));
        end
    endgenerate

    always_comb begin
        cur = '0;
        for (int p = 0; p < NPAGE; p++) begin
            if (ev_page == AW'(p)) begin
                cur = r_q.ent[p];
            end
        end
    end

    pcd_next #(
        .NPROC(NPROC), .PW(PW), .CW(CW), .CNTW(CNTW),
        .NOTICE_LIMIT(NOTICE_LIMIT), .CHECK_LIMIT(CHECK_LIMIT)
    ) u_next (
        .kind       (ev_kind_t'(ev_kind)),
        .proc       (ev_proc),
        .cur_base   (cur.base),
        .cur_unsafe (cur.unsafe),
        .cur_rd     (cur.rd),
        .cur_wr     (cur.wr),
        .cur_pend   (cur.pend),
        .cur_ntc    (cur.ntc),
        .cur_chk    (cur.chk),
        .nx_base    (nxt.base),
        .nx_unsafe  (nxt.unsafe),
        .nx_rd      (nxt.rd),
        .nx_wr      (nxt.wr),
        .nx_pend    (nxt.pend),
        .nx_ntc     (nxt.ntc),
        .nx_chk     (nxt.chk),
        .notify     (nx_notify),
        .inval      (nx_inval),
        .cnt        (nx_cnt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = fire;
        if (fire) begin
            r_d.st  = {nxt.unsafe, nxt.base};
            r_d.cnt = nx_cnt;
            r_d.ntf = nx_notify;
            r_d.inv = nx_inval;
        end
        for (int p = 0; p < NPAGE; p++) begin
            if (hit[p]) begin
                r_d.ent[p] = nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid  = r_q.vld;
    assign rsp_state  = r_q.st;
    assign rsp_count  = r_q.cnt;
    assign rsp_notify = r_q.ntf;
    assign rsp_inval  = r_q.inv;
endmodule

// File: rtl/pcd_dir_unit_chk.sv
module pcd_dir_unit_chk #(
    parameter int NPROC = 4,
    parameter int PW    = 2,
    parameter int CNTW  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic             ev_ready,
    input logic [1:0]       ev_kind,
    input logic [PW-1:0]    ev_proc,
    input logic             rsp_valid,
    input logic [2:0]       rsp_state,
    input logic [CNTW-1:0]  rsp_count,
    input logic [NPROC-1:0] rsp_notify,
    input logic             rsp_inval
);
    AST_RSP_AFTER_EVENT: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready) |=> rsp_valid); // R2

    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(ev_valid && ev_ready) |=> !rsp_valid); // R2

    AST_NOTIFY_SKIPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready) |=> (rsp_notify[$past(ev_proc)] == 1'b0)); // R7

    AST_NOTIFY_SAFE_WEAK: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_notify != '0) |-> (rsp_state == 3'b011)); // R8

    AST_UNSAFE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_state[2]) |-> (rsp_notify == '0)); // R9

    AST_INVAL_ONLY_ACQ: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready && ev_kind != 2'd3) |=> !rsp_inval); // R10

    AST_UNC_IFF_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_state[1:0] == 2'd0) == (rsp_count == '0))); // R12

    AST_DIRTY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_state[1:0] == 2'd2) |-> (rsp_count == CNTW'(1))); // R3
endmodule

bind pcd_dir_unit pcd_dir_unit_chk #(
    .NPROC(NPROC), .PW(PW), .CNTW(CNTW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_kind    (ev_kind),
    .ev_proc    (ev_proc),
    .rsp_valid  (rsp_valid),
    .rsp_state  (rsp_state),
    .rsp_count  (rsp_count),
    .rsp_notify (rsp_notify),
    .rsp_inval  (rsp_inval)
);

// File: tb/tb_pcd_dir_unit.sv
`timescale 1ns/1ps
module tb_pcd_dir_unit;
    localparam int NP = 3;
    localparam int NG = 2;
    localparam int NL = 1;
    localparam int CL = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 1'b0;
    logic       ev_ready;
    logic [1:0] ev_kind = '0;
    logic [1:0] ev_proc = '0;
    logic [0:0] ev_page = '0;
    logic       rsp_valid;
    logic [2:0] rsp_state;
    logic [1:0] rsp_count;
    logic [2:0] rsp_notify;
    logic       rsp_inval;

    always #5 clk = ~clk;

    pcd_dir_unit #(.NPROC(NP), .NPAGE(NG), .NOTICE_LIMIT(NL), .CHECK_LIMIT(CL)) dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_kind(ev_kind), .ev_proc(ev_proc), .ev_page(ev_page),
        .rsp_valid(rsp_valid), .rsp_state(rsp_state), .rsp_count(rsp_count),
        .rsp_notify(rsp_notify), .rsp_inval(rsp_inval)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference model of each page, built from the requirements
    int       m_base [NG];
    bit       m_uns  [NG];
    bit [2:0] m_rd   [NG];
    bit [2:0] m_wr   [NG];
    bit [2:0] m_pd   [NG];
    int       m_ntc  [NG];
    int       m_chk  [NG];
    int       e_st, e_cnt, e_ntf, e_inv;

    task automatic chk(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic model(int k, int p, int g);
        bit [2:0] pm;
        bit [2:0] held;
        int       was;
        int       c;
        pm    = 3'b001 << p;
        was   = m_base[g];
        e_ntf = 0;
        e_inv = 0;
        if (k == 0) begin
            m_rd[g] = m_rd[g] | pm;
        end else if (k == 1) begin
            if ((m_wr[g] & pm) == 0) m_pd[g] = m_pd[g] | pm;
        end else if (k == 2) begin
            if ((m_pd[g] & pm) != 0) begin
                m_wr[g] = m_wr[g] | pm;
                m_pd[g] = m_pd[g] & ~pm;
            end
        end else begin
            if (was == 3 && ((m_rd[g] | m_wr[g] | m_pd[g]) & pm) != 0) begin
                m_rd[g] = m_rd[g] & ~pm;
                m_wr[g] = m_wr[g] & ~pm;
                m_pd[g] = m_pd[g] & ~pm;
                e_inv = 1;
            end
        end
        held = m_rd[g] | m_wr[g] | m_pd[g];
        c    = $countones(held);
        if (k == 3) begin
            if (c == 0) m_base[g] = 0;
            if (was != 3 && m_uns[g]) begin
                m_chk[g] = m_chk[g] + 1;
                if (m_chk[g] > CL) begin
                    m_uns[g] = 1'b0;
                    m_chk[g] = 0;
                    m_ntc[g] = 0;
                end
            end
        end else begin
            if (was != 3) begin
                if (c == 0)            m_base[g] = 0;
                else if (c == 1)       m_base[g] = 2;
                else if (m_wr[g] != 0) m_base[g] = 3;
                else                   m_base[g] = 1;
            end
            if (was != 3 && m_base[g] == 3 && !m_uns[g]) begin
                if (m_ntc[g] <= NL) begin
                    e_ntf    = int'(held & ~pm);
                    m_ntc[g] = m_ntc[g] + 1;
                end else begin
                    m_uns[g] = 1'b1;
                    m_chk[g] = 0;
                end
            end
        end
        e_st  = (m_uns[g] ? 4 : 0) + m_base[g];
        e_cnt = c;
    endtask

    task automatic do_ev(int k, int p, int g, string tag);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind  = 2'(k);
        ev_proc  = 2'(p);
        ev_page  = 1'(g);
        @(negedge clk);
        ev_valid = 1'b0;
        model(k, p, g);
        chk(tag, "rsp_valid", int'(rsp_valid), 1);
        chk(tag, "rsp_state", int'(rsp_state), e_st);
        chk(tag, "rsp_count", int'(rsp_count), e_cnt);
        chk(tag, "rsp_notify", int'(rsp_notify), e_ntf);
        chk(tag, "rsp_inval", int'(rsp_inval), e_inv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: got hung run expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit [15:0] lfsr;
        for (int g = 0; g < NG; g++) begin
            m_base[g] = 0; m_uns[g] = 0; m_rd[g] = 0; m_wr[g] = 0;
            m_pd[g] = 0; m_ntc[g] = 0; m_chk[g] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "ev_ready", int'(ev_ready), 1);
        do_ev(3, 0, 0, "R1");
        chk("R12", "uncached state", int'(rsp_state), 0);

        // page 0 walk: safe episodes
        do_ev(0, 0, 0, "R3");
        chk("R3", "dirty literal", int'(rsp_state), 2);
        do_ev(0, 1, 0, "R3");
        chk("R3", "shared literal", int'(rsp_state), 1);
        do_ev(1, 2, 0, "R4");
        chk("R4", "deferred write stays shared", int'(rsp_state), 1);
        @(negedge clk);
        chk("R2", "idle rsp_valid", int'(rsp_valid), 0);
        do_ev(2, 2, 0, "R5");
        chk("R7", "notify literal", int'(rsp_notify), 3);
        chk("R5", "weak literal", int'(rsp_state), 3);
        do_ev(3, 0, 0, "R10");
        chk("R10", "inval literal", int'(rsp_inval), 1);
        do_ev(3, 0, 0, "R10");
        do_ev(3, 1, 0, "R10");
        do_ev(3, 2, 0, "R12");
        do_ev(0, 0, 0, "R3");
        do_ev(1, 1, 0, "R4");
        do_ev(2, 1, 0, "R7");
        chk("R7", "second notice literal", int'(rsp_notify), 1);
        do_ev(3, 0, 0, "R10");
        do_ev(3, 1, 0, "R12");
        // notice budget spent
        do_ev(0, 0, 0, "R3");
        do_ev(1, 1, 0, "R4");
        do_ev(2, 1, 0, "R8");
        chk("R8", "unsafe weak literal", int'(rsp_state), 7);
        chk("R8", "no notices literal", int'(rsp_notify), 0);
        do_ev(0, 2, 0, "R6");
        do_ev(1, 2, 0, "R6");
        do_ev(3, 0, 0, "R10");
        do_ev(3, 1, 0, "R10");
        do_ev(3, 2, 0, "R12");
        chk("R12", "unsafe uncached literal", int'(rsp_state), 4);
        do_ev(0, 0, 0, "R9");
        do_ev(1, 1, 0, "R9");
        do_ev(2, 1, 0, "R9");
        do_ev(3, 0, 0, "R10");
        do_ev(3, 1, 0, "R12");
        // clean checks return the page to safe
        do_ev(0, 0, 0, "R11");
        do_ev(3, 0, 0, "R11");
        chk("R11", "still unsafe literal", int'(rsp_state), 6);
        do_ev(3, 0, 0, "R11");
        chk("R11", "safe again literal", int'(rsp_state), 2);

        // page 1 independence
        do_ev(1, 0, 1, "R13");
        chk("R4", "single writer dirty literal", int'(rsp_state), 2);
        do_ev(0, 1, 1, "R4");
        do_ev(2, 0, 1, "R5");
        chk("R5", "page1 notify literal", int'(rsp_notify), 2);
        do_ev(2, 2, 0, "R13");
        chk("R13", "page0 unchanged literal", int'(rsp_state), 2);

        // pseudo-random sweep
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_ev(int'(lfsr[1:0]), int'(lfsr[7:4]) % NP, int'(lfsr[9]), "R13");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule